// File: doc/BRIEF.md
# Serial ADC Read Controller

This block is the host-side master for a 12-bit successive-approximation converter whose serial clock is also its conversion clock. A start request pulls chip select low. That one edge makes the converter sample its input, begin converting and present its first output bit. The controller then produces exactly sixteen serial clock periods, each half period lasting a parameterised number of system clocks, and samples the data line on every falling edge.

A frame is four zero bits followed by the 12-bit result, most significant bit first. When the sixteenth period ends, the controller raises chip select with the clock parked high. In that same cycle it presents the result with a one-cycle valid strobe. It also raises a framing-error flag if any of the four leading bits was not zero.

An abort request ends the frame early, and the controller reports that case separately from a valid result. After every frame a programmable quiet interval passes before the next frame can begin. The busy output covers the whole frame and the quiet interval, and start requests that arrive while busy is high are dropped.

Top module: `adc_rd_ctrl`

## Requirements
- R1: While reset is held and after it is released with no start request: cs_no=1, sclk_o=1, busy_o=0, valid_o=0, aborted_o=0 and frame_err_o=0.
- R2: A start_i high while busy_o is low drives cs_no low and busy_o high at the next clock edge.
- R3: A frame that is not aborted keeps cs_no low for exactly 32*HALF_DIV system cycles and produces exactly 16 falling sclk_o edges. The first falling edge comes HALF_DIV cycles after cs_no falls. sclk_o is high whenever cs_no is high, and it rises in the same cycle that cs_no rises.
- R4: sdata_i is sampled on each of the 16 falling sclk_o edges. The first sample takes the bit presented since cs_no fell. Samples 5 to 16 become data_o[11:0], in order from bit 11 down to bit 0, and data_o holds that value until the next completed frame.
- R5: valid_o is a one-cycle pulse in the cycle in which cs_no rises at the end of a completed frame.
- R6: frame_err_o pulses together with valid_o exactly when any of samples 1 to 4 was 1.
- R7: abort_i high while cs_no is low raises cs_no at the next edge with sclk_o high. In that same cycle aborted_o pulses for one cycle. valid_o stays low and data_o is unchanged.
- R8: After cs_no rises, busy_o stays high for quiet_cycles_i+1 cycles and then falls. quiet_cycles_i is read in the cycle cs_no rises.
- R9: start_i while busy_o is high has no effect: cs_no stays high through the quiet interval.
- R10: abort_i while busy_o is low has no effect: aborted_o stays low and cs_no stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request one frame |
| abort_i | input | 1 | Terminate the frame in progress |
| quiet_cycles_i | input | QUIET_W | Quiet interval length, in cycles beyond one |
| sdata_i | input | 1 | Converter serial data |
| cs_no | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock, idles high |
| busy_o | output | 1 | Frame or quiet interval in progress |
| valid_o | output | 1 | Result strobe |
| frame_err_o | output | 1 | Leading bits not zero, pulses with valid_o |
| aborted_o | output | 1 | Frame was terminated by abort_i |
| data_o | output | 12 | Last completed result |

## Verification
The assertions assume that sdata_i changes only after a falling serial clock edge and that quiet_cycles_i is stable around the end of a frame. The bench meets both conditions with a converter model that updates its output only on falling edges of sclk_o and on the falling edge of cs_no, and it sets quiet_cycles_i only before a frame starts. Start and abort requests are one-cycle pulses driven between clock edges. The bench chooses abort points inside the 32*HALF_DIV window so that every abort lands while chip select is low.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
  localparam int FRAME_BITS = 16;
  localparam int LEAD_BITS  = 4;
  localparam int RES_BITS   = FRAME_BITS - LEAD_BITS;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_XFER  = 2'd1,
    ST_QUIET = 2'd2
  } st_e;
endpackage

// File: rtl/adc_sclk_div.sv
module adc_sclk_div #(
  parameter int HALF_DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic sclk_o,
  output logic fall_o,
  output logic rise_o
);
  localparam int DW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;

  logic [DW-1:0] cnt_q;
  logic          sclk_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == DW'(HALF_DIV - 1));
  assign fall_o = tick && sclk_q;
  assign rise_o = tick && !sclk_q;
  assign sclk_o = sclk_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (!run_i) begin
      cnt_q  <= '0;
      sclk_q <= 1'b1;
    end else if (tick) begin
      cnt_q  <= '0;
      sclk_q <= !sclk_q;
    end else begin
      cnt_q  <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/adc_frame_shift.sv
module adc_frame_shift
  import adc_rd_pkg::*;
(
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  clr_i,
  input  logic                  cap_i,
  input  logic                  sdata_i,
  output logic [FRAME_BITS-1:0] frame_o,
  output logic                  full_o
);
  logic [FRAME_BITS-1:0] sh_q;
  logic [CNT_W-1:0]      n_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (clr_i) begin
      sh_q <= '0;
      n_q  <= '0;
    end else if (cap_i) begin
      sh_q <= {sh_q[FRAME_BITS-2:0], sdata_i};
      n_q  <= n_q + 1'b1;
    end
  end

  assign frame_o = sh_q;
  assign full_o  = (n_q == CNT_W'(FRAME_BITS));
endmodule

// File: rtl/adc_quiet_timer.sv
module adc_quiet_timer #(
  parameter int QUIET_W = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               load_i,
  input  logic               run_i,
  input  logic [QUIET_W-1:0] len_i,
  output logic               done_o
);
  logic [QUIET_W-1:0] len_q;
  logic [QUIET_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      len_q <= '0;
      cnt_q <= '0;
    end else if (load_i) begin
      len_q <= len_i;
      cnt_q <= '0;
    end else if (run_i && !done_o) begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  assign done_o = (cnt_q >= len_q);
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
  import adc_rd_pkg::*;
#(
  parameter int HALF_DIV = 4,
  parameter int QUIET_W  = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               abort_i,
  input  logic [QUIET_W-1:0] quiet_cycles_i,
  input  logic               sdata_i,
  output logic               cs_no,
  output logic               sclk_o,
  output logic               busy_o,
  output logic               valid_o,
  output logic               frame_err_o,
  output logic               aborted_o,
  output logic [RES_BITS-1:0] data_o
);
  st_e st_q, st_d;

  logic                  run;
  logic                  fall, rise;
  logic                  full;
  logic [FRAME_BITS-1:0] frame;
  logic                  q_done;
  logic                  go, fin, abt;

  assign go  = (st_q == ST_IDLE) && start_i;
  assign abt = (st_q == ST_XFER) && abort_i;
  assign fin = (st_q == ST_XFER) && !abort_i && rise && full;
  // divider stops in the abort cycle so sclk is high when cs rises
  assign run = (st_q == ST_XFER) && !abort_i;

  adc_sclk_div #(.HALF_DIV(HALF_DIV)) u_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .sclk_o (sclk_o),
    .fall_o (fall),
    .rise_o (rise)
  );

  adc_frame_shift u_shift (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (go),
    .cap_i   (fall && run),
    .sdata_i (sdata_i),
    .frame_o (frame),
    .full_o  (full)
  );

  adc_quiet_timer #(.QUIET_W(QUIET_W)) u_quiet (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (fin || abt),
    .run_i  (st_q == ST_QUIET),
    .len_i  (quiet_cycles_i),
    .done_o (q_done)
  );

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (start_i) st_d = ST_XFER;
      ST_XFER:  if (abt || fin) st_d = ST_QUIET;
      ST_QUIET: if (q_done) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      cs_no       <= 1'b1;
      valid_o     <= 1'b0;
      frame_err_o <= 1'b0;
      aborted_o   <= 1'b0;
      data_o      <= '0;
    end else begin
      st_q        <= st_d;
      cs_no       <= (st_d != ST_XFER);
      valid_o     <= fin;
      aborted_o   <= abt;
      frame_err_o <= fin && (|frame[FRAME_BITS-1:RES_BITS]);
      if (fin) data_o <= frame[RES_BITS-1:0];
    end
  end

  assign busy_o = (st_q != ST_IDLE);
endmodule

// File: rtl/adc_rd_chk.sv
module adc_rd_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic cs_no,
  input logic sclk_o,
  input logic busy_o,
  input logic valid_o,
  input logic frame_err_o,
  input logic aborted_o
);
  logic       sclk_p, cs_p;
  logic [4:0] falls_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_p  <= 1'b1;
      cs_p    <= 1'b1;
      falls_q <= '0;
    end else begin
      sclk_p <= sclk_o;
      cs_p   <= cs_no;
      if (cs_p && !cs_no) falls_q <= '0;
      else if (sclk_p && !sclk_o && !cs_no) falls_q <= falls_q + 1'b1;
    end
  end

  // R2
  start_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && start_i) |=> (!cs_no && busy_o));
  // R3
  sclk_idle_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_no |-> sclk_o);
  // R3
  fall_limit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    falls_q <= 5'd16);
  // R5
  valid_on_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> $rose(cs_no));
  // R5
  valid_full_frame_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> (falls_q == 5'd16));
  // R6
  ferr_with_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_err_o |-> valid_o);
  // R7
  abort_no_valid_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_o && aborted_o));
  // R7
  abort_cs_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aborted_o |-> $rose(cs_no));
  // R8
  busy_cover_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |-> busy_o);
endmodule

bind adc_rd_ctrl adc_rd_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .start_i     (start_i),
  .cs_no       (cs_no),
  .sclk_o      (sclk_o),
  .busy_o      (busy_o),
  .valid_o     (valid_o),
  .frame_err_o (frame_err_o),
  .aborted_o   (aborted_o)
);

// File: tb/tb_adc_rd_ctrl.sv
module tb_adc_rd_ctrl;
  localparam int H  = 4;
  localparam int QW = 8;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0, abort = 1'b0;
  logic [QW-1:0] quiet = '0;
  logic          sdata = 1'b0;
  logic          cs_n, sclk, busy, valid, ferr, aborted;
  logic [11:0]   data;

  int tests = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  adc_rd_ctrl #(.HALF_DIV(H), .QUIET_W(QW)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .abort_i(abort),
    .quiet_cycles_i(quiet), .sdata_i(sdata), .cs_no(cs_n), .sclk_o(sclk),
    .busy_o(busy), .valid_o(valid), .frame_err_o(ferr), .aborted_o(aborted),
    .data_o(data));

  // converter model
  logic [15:0] conv_frame = '0;
  int          bit_idx = 0;
  int          fall_cnt = 0;
  always @(negedge cs_n) begin
    bit_idx = 0;
    sdata = conv_frame[15];
  end
  always @(negedge sclk) if (!cs_n) begin
    fall_cnt++;
    bit_idx++;
    sdata = (bit_idx < 16) ? conv_frame[15 - bit_idx] : 1'b0;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic bit exp_ferr(input logic [15:0] f);
    return |f[15:12];
  endfunction

  // one frame; abort_at=0 means run to completion
  task automatic run_txn(input logic [15:0] f, input int q, input int abort_at);
    int n;
    logic [11:0] prev;
    prev = data;
    conv_frame = f;
    quiet = QW'(q);
    fall_cnt = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check(!cs_n && busy, "R2 cs low and busy after start", {cs_n, busy}, 2'b01);
    if (abort_at > 0) begin
      repeat (abort_at - 1) @(negedge clk);
      abort = 1'b1;
      @(negedge clk);
      abort = 1'b0;
      check(cs_n && sclk && aborted && !valid, "R7 abort ends frame",
            {cs_n, sclk, aborted, valid}, 4'b1110);
      check(data == prev, "R7 data unchanged on abort", data, prev);
    end else begin
      n = 0;
      while (!cs_n) begin
        n++;
        @(negedge clk);
      end
      check(n == 32 * H, "R3 cs low duration", n, 32 * H);
      check(fall_cnt == 16, "R3 sixteen sclk falls", fall_cnt, 16);
      check(sclk, "R3 sclk high at cs rise", sclk, 1);
      check(valid, "R5 valid at cs rise", valid, 1);
      check(data == f[11:0], "R4 result bits", data, f[11:0]);
      check(ferr == exp_ferr(f), "R6 framing error flag", ferr, exp_ferr(f));
    end
    n = 0;
    while (busy) begin
      start = (n == 1);
      check(cs_n, "R9 start ignored while busy", cs_n, 1);
      n++;
      @(negedge clk);
    end
    start = 1'b0;
    check(n == q + 1, "R8 quiet interval", n, q + 1);
    check(!valid && !aborted, "R5 strobes one cycle", {valid, aborted}, 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check(cs_n && sclk && !busy && !valid && !aborted && !ferr, "R1 reset state",
          {cs_n, sclk, busy, valid, aborted, ferr}, 6'b110000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(cs_n && sclk && !busy && !valid, "R1 idle after reset",
          {cs_n, sclk, busy, valid}, 4'b1100);

    // R10: abort while idle
    abort = 1'b1;
    @(negedge clk);
    abort = 1'b0;
    @(negedge clk);
    check(cs_n && !aborted && !busy, "R10 idle abort ignored", {cs_n, aborted, busy}, 3'b100);

    // directed corners
    run_txn(16'h0FFF, 0, 0);
    run_txn(16'h0000, 3, 0);
    run_txn(16'h0A5C, 1, 0);
    run_txn(16'h8123, 2, 0);
    run_txn(16'h1001, 0, 0);
    run_txn(16'h0777, 2, 1);
    run_txn(16'h0321, 0, 32 * H - 1);

    // random
    for (int i = 0; i < 40; i++) begin
      logic [15:0] f;
      int q, ab;
      f = 16'($urandom);
      if ($urandom_range(3) != 0) f[15:12] = 4'h0;
      q = $urandom_range(6);
      ab = ($urandom_range(4) == 0) ? $urandom_range(32 * H - 1, 1) : 0;
      run_txn(f, q, ab);
    end

    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      tests++;
      fails++;
      $display("FAIL watchdog act=0 exp=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule